// File: doc/BRIEF.md
# Sequence Store With Byte-Stream Programming Port

This block holds a 64-word, 32-bit power-sequencing store and lets a host program it one byte at a time through two 8-bit registers. One is a pointer register and the other is a data window. The host loads the pointer once. It then streams bytes through the data window, and every data access, read or write, moves the pointer on by one. A pointer value is a word index times four plus a byte lane, so four consecutive data writes fill one word.

The store has three regions. The low words hold a fixed factory program, and only their link bytes may be changed. The middle words are free for user sequences. The top word is a fixed terminator. A protected write is silently dropped, but the pointer still advances, so a stream never gets out of step.

A second port gives a sequencing engine a registered full-word read at any index. Host pins are plain strobes with one access per cycle. No back-pressure exists because every access completes in the cycle it is presented.

Top module: `seqmem_port`

## Requirements
- R1: After reset the pointer and `host_rdata` are 0. Factory word i (0..42) reads {8'hA0+i, 8'h50^i, {5'b0,i[2:0]}, link}, where link is i+1, except word 42, whose link is 63. Words 43..62 read 0. Word 63 reads 32'hFFFF_003F.
- R2: A write with `host_sel`=0 loads the pointer from `host_wdata`. A read with `host_sel`=0 returns the pointer on `host_rdata` one cycle later. Without a data access or a pointer load, the pointer holds its value.
- R3: A pointer value p selects word p[7:2] and lane p[1:0]. Lane 0 is word bits [31:24] (message high), lane 1 is [23:16] (message low), lane 2 is [15:8] (delay) and lane 3 is [7:0] (link).
- R4: A write with `host_sel`=1 stores `host_wdata` in the addressed byte if that byte is writable, and increments the pointer.
- R5: A read with `host_sel`=1 returns the addressed byte on `host_rdata` one cycle later and increments the pointer.
- R6: In words 0..42, writes to lanes 0..2 are dropped, and writes to lane 3 take effect.
- R7: Every lane of words 43..62 is writable.
- R8: Word 63 is read-only in all lanes and always reads 32'hFFFF_003F.
- R9: A dropped write still increments the pointer.
- R10: The pointer wraps from 255 to 0 on a data access.
- R11: `eng_word` shows the word at `eng_addr` one cycle after the address is presented. If a host write hits the same word in that cycle, `eng_word` shows the old value first and the new value one cycle later.
- R12: If `host_wr` and `host_rd` are both high, only the write is performed, and `host_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 0 selects the pointer register, 1 selects the data window |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid the cycle after a read |
| eng_addr | input | 6 | Engine word index |
| eng_word | output | 32 | Registered engine word |

## Verification
The engine read and a host byte write can land on the same word in the same cycle. The bench parks `eng_addr` on a spare word and writes its link byte in that cycle. It then expects the old word on the following cycle and the updated word on the cycle after. A second collision places a read strobe and a write strobe on the data window together. The bench judges it by three results: the stored byte, a single pointer step, and an unchanged `host_rdata`.

// File: rtl/seqmem_pkg.sv
package seqmem_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    SEL_PTR  = 1'b0,
    SEL_DATA = 1'b1
  } host_sel_e;

  // Factory program word: message bytes derived from the index, small delay,
  // link to the following word, last factory word links to the terminator.
  function automatic logic [31:0] factory_word(input int unsigned idx,
                                               input int unsigned last,
                                               input int unsigned term);
    logic [7:0] i8;
    logic [7:0] link;
    i8   = 8'(idx);
    link = (idx == last) ? 8'(term) : 8'(idx + 1);
    return {8'hA0 + i8, 8'h50 ^ i8, {5'b0, i8[2:0]}, link};
  endfunction

  function automatic logic [31:0] term_word(input int unsigned term);
    return {16'hFFFF, 8'h00, 8'(term)};
  endfunction

endpackage

// File: rtl/seqmem_ptr.sv
module seqmem_ptr #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr_q
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load) begin
      ptr_q <= load_val;
    end else if (step) begin
      ptr_q <= ptr_q + ONE;   // natural wrap at the top
    end
  end
endmodule

// File: rtl/seqmem_guard.sv
module seqmem_guard #(
  parameter int unsigned WORDS        = 64,
  parameter int unsigned FACTORY_LAST = 42,
  parameter int unsigned WORD_W       = 6
) (
  input  logic              wr,
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        lane,
  output logic [3:0]        lane_we
);
  localparam int unsigned TERM_IDX  = WORDS - 1;
  localparam int unsigned LINK_LANE = 3;

  logic in_factory;
  logic in_term;

  assign in_factory = (32'(word) <= FACTORY_LAST);
  assign in_term    = (32'(word) == TERM_IDX);

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic lane_open;
    if (l == LINK_LANE) begin : g_link
      assign lane_open = !in_term;
    end else begin : g_body
      assign lane_open = !in_term && !in_factory;
    end
    assign lane_we[l] = wr && (lane == 2'(l)) && lane_open;
  end
endmodule

// File: rtl/seqmem_store.sv
module seqmem_store
  import seqmem_pkg::*;
#(
  parameter int unsigned WORDS        = 64,
  parameter int unsigned FACTORY_LAST = 42,
  parameter int unsigned WORD_W       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] host_word,
  input  logic [1:0]        host_lane,
  input  logic [3:0]        lane_we,
  input  logic [7:0]        wr_byte,
  output logic [7:0]        host_byte,
  input  logic [WORD_W-1:0] eng_addr,
  output logic [31:0]       eng_word
);
  localparam int unsigned TERM_IDX = WORDS - 1;

  logic [31:0] mem_q [WORDS];
  logic [31:0] host_sel_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(WORDS); i++) begin
        if (i <= int'(FACTORY_LAST))      mem_q[i] <= factory_word(i, FACTORY_LAST, TERM_IDX);
        else if (i == int'(TERM_IDX))     mem_q[i] <= term_word(TERM_IDX);
        else                              mem_q[i] <= '0;
      end
    end else begin
      for (int l = 0; l < 4; l++) begin
        if (lane_we[l]) mem_q[host_word][(3-l)*8 +: 8] <= wr_byte;
      end
    end
  end

  // Engine port: registered, old data on a same-cycle host write.
  always_ff @(posedge clk) begin
    if (!rst_n) eng_word <= '0;
    else        eng_word <= mem_q[eng_addr];
  end

  assign host_sel_word = mem_q[host_word];
  always_comb begin
    unique case (host_lane)
      2'd0:    host_byte = host_sel_word[31:24];
      2'd1:    host_byte = host_sel_word[23:16];
      2'd2:    host_byte = host_sel_word[15:8];
      default: host_byte = host_sel_word[7:0];
    endcase
  end
endmodule

// File: rtl/seqmem_port.sv
module seqmem_port
  import seqmem_pkg::*;
#(
  parameter int unsigned WORDS        = 64,
  parameter int unsigned FACTORY_LAST = 42
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic [5:0]  eng_addr,
  output logic [31:0] eng_word
);
  localparam int unsigned WORD_W = $clog2(WORDS);
  localparam int unsigned ADDR_W = WORD_W + 2;

  logic [ADDR_W-1:0] ptr_q;
  logic [3:0]        lane_we;
  logic [7:0]        host_byte;
  logic              ptr_load;
  logic              data_wr;
  logic              data_rd;
  logic              do_read;

  assign ptr_load = host_wr && (host_sel == SEL_PTR);
  assign data_wr  = host_wr && (host_sel == SEL_DATA);
  assign do_read  = host_rd && !host_wr;               // write wins
  assign data_rd  = do_read && (host_sel == SEL_DATA);

  seqmem_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (host_wdata[ADDR_W-1:0]),
    .step     (data_wr || data_rd),
    .ptr_q    (ptr_q)
  );

  seqmem_guard #(
    .WORDS(WORDS), .FACTORY_LAST(FACTORY_LAST), .WORD_W(WORD_W)
  ) u_guard (
    .wr      (data_wr),
    .word    (ptr_q[ADDR_W-1:2]),
    .lane    (ptr_q[1:0]),
    .lane_we (lane_we)
  );

  seqmem_store #(
    .WORDS(WORDS), .FACTORY_LAST(FACTORY_LAST), .WORD_W(WORD_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_word (ptr_q[ADDR_W-1:2]),
    .host_lane (ptr_q[1:0]),
    .lane_we   (lane_we),
    .wr_byte   (host_wdata),
    .host_byte (host_byte),
    .eng_addr  (eng_addr[WORD_W-1:0]),
    .eng_word  (eng_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (do_read) begin
      host_rdata <= (host_sel == SEL_DATA) ? host_byte : 8'(ptr_q);
    end
  end
endmodule

// File: rtl/seqmem_chk.sv
module seqmem_chk #(
  parameter int unsigned WORDS        = 64,
  parameter int unsigned FACTORY_LAST = 42
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_sel,
  input logic        host_wr,
  input logic        host_rd,
  input logic [7:0]  host_wdata,
  input logic [7:0]  host_rdata,
  input logic [5:0]  eng_addr,
  input logic [31:0] eng_word,
  input logic [7:0]  ptr_q,
  input logic [3:0]  lane_we
);
  localparam logic [5:0]  TERM     = 6'(WORDS - 1);
  localparam logic [31:0] TERM_VAL = {16'hFFFF, 8'h00, 8'(WORDS - 1)};

  logic data_acc;
  assign data_acc = host_sel && (host_wr || host_rd);

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_sel) |=> (ptr_q == $past(host_wdata))); // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr && !(host_rd && host_sel)) |=> $stable(ptr_q)); // R2
  AST_PTR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && !host_sel) |=> (host_rdata == $past(ptr_q))); // R2
  AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_we)); // R3
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> (ptr_q == 8'($past(ptr_q) + 8'd1))); // R4
  AST_FACTORY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && (ptr_q[7:2] <= 6'(FACTORY_LAST)) && (ptr_q[1:0] != 2'd3))
      |-> (lane_we == 4'b0)); // R6
  AST_TERM_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_addr == TERM) |=> (eng_word == TERM_VAL)); // R8
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && (ptr_q == 8'hFF)) |=> (ptr_q == 8'h00)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd || host_wr) |=> $stable(host_rdata)); // R12
endmodule

bind seqmem_port seqmem_chk #(.WORDS(WORDS), .FACTORY_LAST(FACTORY_LAST)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_sel   (host_sel),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .eng_addr   (eng_addr),
  .eng_word   (eng_word),
  .ptr_q      (ptr_q),
  .lane_we    (lane_we)
);

// File: tb/tb_seqmem_port.sv
module tb_seqmem_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [5:0]  eng_addr = '0;
  logic [31:0] eng_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  seqmem_port dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] fact(input int i);
    logic [7:0] b = 8'(i);
    return {8'hA0 + b, 8'h50 ^ b, {5'b0, b[2:0]}, (i == 42) ? 8'd63 : 8'(i + 1)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One host access: inputs set on a falling edge, result sampled one edge later.
  task automatic acc(input bit sel, input bit wr, input bit rd, input logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic set_ptr(input logic [7:0] p); acc(1'b0, 1'b1, 1'b0, p); endtask

  task automatic chk_ptr(input string req, input logic [7:0] exp);
    acc(1'b0, 1'b0, 1'b1, 8'h00);
    check(req, 32'(host_rdata), 32'(exp));
  endtask

  task automatic eng_rd(input string req, input int w, input logic [31:0] exp);
    @(negedge clk); eng_addr = 6'(w);
    @(negedge clk);
    check(req, eng_word, exp);
  endtask

  task automatic t_reset;
    chk_ptr("R1 ptr", 8'h00);
    check("R1 rdata", 32'(host_rdata), 32'h0);
    eng_rd("R1 word0", 0, fact(0));
    eng_rd("R1 word17", 17, fact(17));
    eng_rd("R1 word42", 42, fact(42));
    eng_rd("R1 word43", 43, 32'h0);
    eng_rd("R1 word62", 62, 32'h0);
    eng_rd("R8 word63", 63, 32'hFFFF_003F);
  endtask

  task automatic t_ptr;
    set_ptr(8'hB5);
    chk_ptr("R2 load", 8'hB5);
    chk_ptr("R2 hold", 8'hB5);
  endtask

  task automatic t_spare;
    set_ptr(8'(45*4));
    acc(1, 1, 0, 8'h12); acc(1, 1, 0, 8'h34); acc(1, 1, 0, 8'h56); acc(1, 1, 0, 8'h78);
    chk_ptr("R4 step", 8'(46*4));
    eng_rd("R3 R7 lane order", 45, 32'h1234_5678);
    set_ptr(8'(45*4 + 2));
    acc(1, 0, 1, 8'h00);
    check("R5 read lane2", 32'(host_rdata), 32'h56);
    chk_ptr("R5 step", 8'(45*4 + 3));
  endtask

  task automatic t_factory;
    set_ptr(8'(10*4));
    acc(1, 1, 0, 8'hEE); acc(1, 1, 0, 8'hEE); acc(1, 1, 0, 8'hEE); acc(1, 1, 0, 8'h2D);
    eng_rd("R6 link only", 10, {fact(10)[31:8], 8'h2D});
    chk_ptr("R9 step on drop", 8'(11*4));
  endtask

  task automatic t_term;
    set_ptr(8'd252);
    acc(1, 1, 0, 8'h01); acc(1, 1, 0, 8'h02); acc(1, 1, 0, 8'h03); acc(1, 1, 0, 8'h04);
    eng_rd("R8 unchanged", 63, 32'hFFFF_003F);
    chk_ptr("R10 wrap on write", 8'h00);
    set_ptr(8'hFF);
    acc(1, 0, 1, 8'h00);
    check("R10 R5 read byte", 32'(host_rdata), 32'h3F);
    chk_ptr("R10 wrap on read", 8'h00);
  endtask

  task automatic t_collide;
    @(negedge clk); eng_addr = 6'd50;
    set_ptr(8'(50*4 + 3));
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_wdata = 8'h77;
    @(negedge clk);
    host_wr = 0;
    check("R11 old word", eng_word, 32'h0);
    @(negedge clk);
    check("R11 new word", eng_word, 32'h0000_0077);
  endtask

  task automatic t_both;
    set_ptr(8'(44*4 + 1));
    acc(1, 0, 1, 8'h00);           // rdata = word44 lane1 = 0
    set_ptr(8'(44*4));
    acc(1, 0, 1, 8'h00);           // prime rdata with lane0 = 0
    set_ptr(8'(44*4 + 1));
    acc(1, 0, 0, 8'h00);           // no-op
    acc(1, 1, 1, 8'h9C);
    check("R12 rdata held", 32'(host_rdata), 32'h0);
    chk_ptr("R12 single step", 8'(44*4 + 2));
    eng_rd("R12 byte stored", 44, 32'h009C_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ptr();
    t_spare();
    t_factory();
    t_term();
    t_collide();
    t_both();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule